// File: doc/BRIEF.md
# Protected Watchdog Reset Timer

This block is a watchdog that runs its counter from a dedicated slow clock, separate from the system clock. Software must pulse a refresh strobe often enough; if the selected timeout passes without one, the block raises a system reset request. The request stays high until the chip reset input arrives. A flag that survives chip reset records whether that reset was caused by the watchdog.

Configuration sits in a small register in the system clock domain. The register holds an enable bit and a 3-bit period select, which picks one of eight timeouts of 2^(BASE_EXP+sel) watchdog-clock cycles. Both fields are protected. They change only through a two-write unlock sequence. A static lock input chooses between two protection levels. At the lower level the watchdog leaves reset disabled, and it may be enabled or disabled through the sequence. At the higher level it leaves reset enabled and can never be turned off. Its period can still be changed through the sequence.

The refresh strobe, the configuration and the chip reset cross into the watchdog domain through two-flop synchronizers. The expiry event crosses back the same way. The refresh uses a toggle handshake with an acknowledge, so a strobe issued while an earlier one is still in flight is kept rather than dropped. Chip reset must be held for at least three watchdog-clock cycles.

Top module: `wdt_top`

## Requirements
- R1: After chip reset the register reads psel=0 (bits 2:0) and change-window=0 (bit 4). The enable bit (bit 3) equals the lock input: 0 (disabled) when lock is low, 1 when lock is high.
- R2: A write with bit 4 and bit 3 both set opens a change window. A write on any of the next 4 system clock edges loads the enable bit from bit 3 and the period select from bits 2:0, and visible on the following read.
- R3: A write made while no window is open leaves the register unchanged. The window closes by itself after 4 edges with no write, and it closes immediately after the write that it accepts.
- R4: With the lock input high, the enable bit stays 1 even when a window write carries bit 3 = 0; the period select is still updated.
- R5: While enabled, the reset request rises once 2^(BASE_EXP+psel) watchdog-clock cycles have passed with no refresh, plus synchronizer latency.
- R6: A refresh strobe restarts the count from zero. Strobes on consecutive cycles are not lost, and refreshing faster than the timeout keeps the reset request low.
- R7: While disabled the count is held at zero and no reset request is raised. Re-enabling later gives a full timeout.
- R8: The reset request stays high until chip reset. The reset-source flag becomes 1 on a chip reset that finds the request high, and 0 on a chip reset that finds it low.
- R9: Bit 4 of the read value shows 1 while a change window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Chip reset, synchronous, active high |
| wdt_clk | input | 1 | Dedicated watchdog oscillator clock |
| lock_lvl | input | 1 | Static protection level: 1 = always enabled |
| refresh | input | 1 | Refresh strobe, one system cycle per refresh |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 5 | Write data: [2:0] period select, [3] enable, [4] change-enable |
| bus_rdata | output | 5 | Read data: [2:0] period select, [3] enable, [4] window open |
| sys_reset_req | output | 1 | System reset request, held until chip reset |
| wdt_reset_flag | output | 1 | Last chip reset was caused by the watchdog |

## Verification
A refresh strobe and the configuration write that closes the change window can land in the same system cycle. The bench provokes this by raising refresh together with the last accepted window write. It then judges two things: the register must take the new enable and period exactly as the reference model predicts, and the reset request must rise no earlier than a full new period after that cycle. Refresh bursts, including back-to-back strobes while a handshake is still in flight, are checked by confirming that the request stays low throughout. Every system cycle, the register read value is compared against a behavioural model of the window and the protection level.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PSEL_W = 3;
  localparam int CFG_W  = 5;
  localparam int BIT_EN = 3;
  localparam int BIT_CE = 4;

  typedef struct packed {
    logic              en;
    logic [PSEL_W-1:0] psel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg import wdt_pkg::*; #(
  parameter int WIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_lvl,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output wdt_cfg_t         cfg,
  output logic             win_open
);
  localparam int WCW = $clog2(WIN_LEN + 1);

  logic [WCW-1:0] win;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.en   <= lock_lvl;
      cfg.psel <= '0;
      win      <= '0;
    end else if (win != '0) begin
      if (wr) begin
        cfg.psel <= wdata[PSEL_W-1:0];
        cfg.en   <= lock_lvl | wdata[BIT_EN];
        win      <= '0;
      end else begin
        win <= win - 1'b1;
      end
    end else if (wr && wdata[BIT_CE] && wdata[BIT_EN]) begin
      win <= WCW'(WIN_LEN);
    end
  end

  assign win_open = (win != '0);

  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr) |=> (cfg.psel == $past(wdata[PSEL_W-1:0]))); // R2
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr) |=> !win_open); // R3
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> ($stable(cfg.psel) && $stable(cfg.en))); // R3
  AST_LVL2_ON: assert property (@(posedge clk) disable iff (rst)
    lock_lvl |=> cfg.en); // R4
endmodule

// File: rtl/wdt_core.sv
module wdt_core import wdt_pkg::*; #(
  parameter int BASE_EXP = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  input  logic              req_tgl,
  output logic              ack_tgl,
  output logic              expired
);
  localparam int CW = BASE_EXP + (1 << PSEL_W);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          hit;

  always_comb begin
    hit    = req_tgl ^ ack_tgl;
    lim_m1 = (CW'(1) << (BASE_EXP + int'(psel))) - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ack_tgl <= 1'b0;
    else     ack_tgl <= req_tgl;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || hit) begin
      cnt <= '0;
    end else if (!expired && cnt != lim_m1) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) expired <= 1'b0;
    else if (en && !hit && cnt == lim_m1) expired <= 1'b1;
  end

  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en && !expired) |=> !expired); // R7
  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> ($past(cnt) == $past(lim_m1))); // R5
endmodule

// File: rtl/wdt_top.sv
module wdt_top import wdt_pkg::*; #(
  parameter int BASE_EXP = 14,
  parameter int WIN_LEN  = 4
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             wdt_clk,
  input  logic             lock_lvl,
  input  logic             refresh,
  input  logic             bus_wr,
  input  logic [CFG_W-1:0] bus_wdata,
  output logic [CFG_W-1:0] bus_rdata,
  output logic             sys_reset_req,
  output logic             wdt_reset_flag
);
  wdt_cfg_t cfg, cfg_w;
  logic     win_open;
  logic     wrst, req_tgl, req_w, ack_w, ack_s, pend, exp_w, exp_s, armed, rst_d;

  wdt_cfg #(.WIN_LEN(WIN_LEN)) u_cfg (
    .clk(sys_clk), .rst(sys_rst), .lock_lvl(lock_lvl), .wr(bus_wr),
    .wdata(bus_wdata), .cfg(cfg), .win_open(win_open)
  );

  always_comb begin
    bus_rdata = '0;
    bus_rdata[PSEL_W-1:0] = cfg.psel;
    bus_rdata[BIT_EN]     = cfg.en;
    bus_rdata[BIT_CE]     = win_open;
  end

  // system -> watchdog domain
  wdt_sync #(.W(1))          u_sync_rst (.clk(wdt_clk), .d(sys_rst), .q(wrst));
  wdt_sync #(.W($bits(cfg))) u_sync_cfg (.clk(wdt_clk), .d(cfg),     .q(cfg_w));
  wdt_sync #(.W(1))          u_sync_req (.clk(wdt_clk), .d(req_tgl), .q(req_w));
  // watchdog -> system domain
  wdt_sync #(.W(1))          u_sync_ack (.clk(sys_clk), .d(ack_w),   .q(ack_s));
  wdt_sync #(.W(1))          u_sync_exp (.clk(sys_clk), .d(exp_w),   .q(exp_s));

  wdt_core #(.BASE_EXP(BASE_EXP)) u_core (
    .clk(wdt_clk), .rst(wrst), .en(cfg_w.en), .psel(cfg_w.psel),
    .req_tgl(req_w), .ack_tgl(ack_w), .expired(exp_w)
  );

  // refresh toggle handshake; strobes during a busy handshake are merged
  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      req_tgl <= 1'b0;
      pend    <= 1'b0;
    end else if ((ack_s == req_tgl) && (refresh || pend)) begin
      req_tgl <= ~req_tgl;
      pend    <= 1'b0;
    end else if (refresh) begin
      pend <= 1'b1;
    end
  end

  // reset request: armed only after the expiry flag is seen low post-reset
  always_ff @(posedge sys_clk) begin
    rst_d <= sys_rst;
    if (sys_rst) begin
      armed         <= 1'b0;
      sys_reset_req <= 1'b0;
      if (sys_reset_req)  wdt_reset_flag <= 1'b1;
      else if (!rst_d)    wdt_reset_flag <= 1'b0;
    end else begin
      if (!exp_s)         armed <= 1'b1;
      if (armed && exp_s) sys_reset_req <= 1'b1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sys_reset_req |=> sys_reset_req); // R8
  AST_FLAG_SET: assert property (@(posedge sys_clk)
    (sys_rst && sys_reset_req) |=> wdt_reset_flag); // R8
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int SYS_PERIOD = 10;
  localparam int WDT_PERIOD = 26;
  localparam int BASE       = 4;

  logic       sys_clk = 1'b0, wdt_clk = 1'b0;
  logic       sys_rst = 1'b1, lock_lvl = 1'b0, refresh = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_wdata = '0;
  logic [4:0] bus_rdata;
  logic       sys_reset_req, wdt_reset_flag;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
  always #(WDT_PERIOD/2) wdt_clk = ~wdt_clk;

  wdt_top #(.BASE_EXP(BASE), .WIN_LEN(4)) dut (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .wdt_clk(wdt_clk), .lock_lvl(lock_lvl),
    .refresh(refresh), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_reset_req(sys_reset_req), .wdt_reset_flag(wdt_reset_flag)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_en = 0, m_psel = 0, m_win = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model of the protected register (R1 R2 R3 R4 R9)
  always @(posedge sys_clk) begin
    cyc++;
    if (sys_rst) begin
      m_en = lock_lvl ? 1 : 0; m_psel = 0; m_win = 0;
    end else if (m_win > 0) begin
      if (bus_wr) begin
        m_psel = int'(bus_wdata[2:0]);
        m_en   = (lock_lvl || bus_wdata[3]) ? 1 : 0;
        m_win  = 0;
      end else m_win--;
    end else if (bus_wr && bus_wdata[4] && bus_wdata[3]) m_win = 4;
  end

  always @(negedge sys_clk) begin
    if (cyc >= 2) begin
      int exp_rd;
      exp_rd = (m_win > 0 ? 16 : 0) + m_en * 8 + m_psel;
      chk(int'(bus_rdata) == exp_rd, "R2/R3 register model", int'(bus_rdata), exp_rd);
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    sys_rst = 1'b1;
    repeat (10) @(negedge sys_clk);
    sys_rst = 1'b0;
    @(negedge sys_clk);
  endtask

  task automatic wr_bus(input logic [4:0] d, input bit rf);
    bus_wr = 1'b1; bus_wdata = d; refresh = rf;
    @(negedge sys_clk);
    bus_wr = 1'b0; refresh = 1'b0;
  endtask

  task automatic unlock_write(input logic [4:0] d);
    wr_bus(5'h18, 1'b0);
    wr_bus(d, 1'b0);
  endtask

  task automatic wait_req(input int lo, input int hi, input string tag);
    int n;
    n = 0;
    while (!sys_reset_req && n <= hi) begin
      @(negedge sys_clk);
      n++;
    end
    chk(n >= lo && n <= hi, tag, n, lo);
  endtask

  task automatic quiet(input int len, input string tag);
    int hi_cnt;
    hi_cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge sys_clk);
      if (sys_reset_req) hi_cnt++;
    end
    chk(hi_cnt == 0, tag, hi_cnt, 0);
  endtask

  initial begin
    do_reset();
    chk(bus_rdata == 5'h00, "R1 level1 reset value", int'(bus_rdata), 0);
    chk(!sys_reset_req, "R1 no request after reset", int'(sys_reset_req), 0);

    wr_bus(5'h0F, 1'b0);
    chk(bus_rdata == 5'h00, "R3 locked write ignored", int'(bus_rdata), 0);

    wr_bus(5'h18, 1'b0);
    chk(bus_rdata[4], "R9 window visible", int'(bus_rdata[4]), 1);
    repeat (4) @(negedge sys_clk);
    chk(!bus_rdata[4], "R3 window self-clears", int'(bus_rdata[4]), 0);
    wr_bus(5'h0B, 1'b0);
    chk(bus_rdata == 5'h00, "R3 late write ignored", int'(bus_rdata), 0);

    // last window slot, refresh in the same cycle as the accepted write
    wr_bus(5'h18, 1'b0);
    repeat (3) @(negedge sys_clk);
    wr_bus(5'h0A, 1'b1);
    chk(bus_rdata == 5'h0A, "R2 last-slot write taken", int'(bus_rdata), 10);
    wait_req(165, 186, "R5 timeout psel2");

    quiet(0, "R8 dummy");
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge sys_clk);
        if (!sys_reset_req) lows++;
      end
      chk(lows == 0, "R8 request held", lows, 0);
    end
    do_reset();
    chk(!sys_reset_req, "R8 request cleared by reset", int'(sys_reset_req), 0);
    chk(wdt_reset_flag, "R8 flag set", int'(wdt_reset_flag), 1);

    // refresh keeps it alive, back-to-back strobes included
    unlock_write(5'h08);
    for (int k = 0; k < 25; k++) begin
      int hits;
      hits = 0;
      for (int i = 0; i < 13; i++) begin
        @(negedge sys_clk);
        if (sys_reset_req) hits++;
      end
      refresh = 1'b1; @(negedge sys_clk);
      refresh = (k % 5 == 0); @(negedge sys_clk);
      refresh = 1'b0;
      if (k == 24) chk(hits == 0 && !sys_reset_req, "R6 refresh keeps request low", hits, 0);
    end
    wait_req(38, 70, "R6 timeout after last refresh");

    do_reset();
    unlock_write(5'h08);
    repeat (3) @(negedge sys_clk);
    unlock_write(5'h00);
    chk(bus_rdata == 5'h00, "R7 disabled via window", int'(bus_rdata), 0);
    quiet(300, "R7 no request while disabled");
    unlock_write(5'h08);
    wait_req(38, 62, "R7 full period after re-enable");

    do_reset();
    chk(wdt_reset_flag, "R8 flag after watchdog reset", int'(wdt_reset_flag), 1);
    do_reset();
    chk(!wdt_reset_flag, "R8 flag cleared by plain reset", int'(wdt_reset_flag), 0);

    lock_lvl = 1'b1;
    do_reset();
    chk(bus_rdata == 5'h08, "R1 level2 starts enabled", int'(bus_rdata), 8);
    unlock_write(5'h03);
    chk(bus_rdata == 5'h0B, "R4 enable stays, period changes", int'(bus_rdata), 11);
    wait_req(0, 400, "R4 cannot be disabled");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule